// File: doc/BRIEF.md
# DRAM Frequency Retiming Sequencer

This block steps a DRAM subsystem safely from one clock frequency to another. A single start request launches a fixed series of steps. Traffic is held off, periodic impedance calibration and auto-refresh are frozen, and the memory is put into self-refresh. The clock generator is then told to switch, and the PHY is re-initialised. After that the memory leaves self-refresh, the DQS gate is retrained, and everything is handed back in a safe order. The block talks to the memory controller, the clock generator and the PHY through level-held request outputs, and waits on their status inputs.

The target frequency (in MHz), the memory type code, the base refresh interval and the live calibration setting are all captured when a start is accepted. The refresh interval is rescaled by frequency band. The PHY command is chosen by frequency. One down-counter, scaled by a clocks-per-microsecond parameter, times the two fixed waits. Every status poll has a timeout. When a poll times out, the block stops in a sticky error state instead of hanging.

Top module: `dram_retime_seq`

## Requirements
- R1: `start` is taken only when the block is idle or in error; a `start` while `busy` is high has no effect. `busy` rises the cycle after acceptance and stays high until the cycle `done` or `error` rises.
- R2: `host_block` rises the cycle after acceptance. Calibration, refresh and interval outputs stay untouched for SETTLE_US*CLK_PER_US cycles before being frozen.
- R3: While idle, `cal_en` follows `cal_cfg`. At the freeze step it is cleared to 0. In the final step it is restored to the value `cal_cfg` had at acceptance, even if `cal_cfg` changed meanwhile.
- R4: `refresh_en` goes low at the freeze step. It goes high again only after training completes, and one cycle before `host_block` drops.
- R5: At the freeze step `refi` is loaded from the captured base interval: base/4 (shift right by 2) when the target is below 300 MHz, base/2 from 300 up to 671 MHz, and the full base at 672 MHz and above.
- R6: `sr_req` rises at the freeze step. `clk_switch` is raised only after `ctl_mode` reads 3. After `sr_req` falls, the block waits EXIT_US*CLK_PER_US cycles and then waits for `ctl_mode` to read 1.
- R7: `clk_switch` is held until `pll_locked` is seen. No PHY command is issued before that.
- R8: The PHY init command on `phy_cmd` is 1 (PHY PLL bypassed) when the target is at most 800 MHz and 2 (PHY PLL used) above 800 MHz. It is held until `phy_done`, and `sr_req` falls in the same step.
- R9: `gate_ext` is cleared one cycle before the training command (`phy_cmd` = 3) is issued. After training it is set to 1 only for memory type codes 6 and 7, and otherwise to 0.
- R10: If an awaited status is absent for POLL_MAX consecutive cycles, the block enters an error state. There `error` is 1, `busy` is 0 and all outputs hold. A new `start` clears `error` and runs the whole sequence again.
- R11: Completion is marked by a one-cycle `done` pulse, with `busy` already low, in the same cycle `cal_en` is restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a frequency change |
| tgt_mhz | input | FREQ_W | Target frequency in MHz |
| mem_kind | input | 3 | Memory type code (6 and 7 are low-power types) |
| base_refi | input | REFI_W | Refresh interval for full speed |
| cal_cfg | input | 3 | Live periodic-calibration enable field |
| ctl_mode | input | 3 | Controller operating mode (1 normal, 3 self-refresh) |
| pll_locked | input | 1 | Clock generator lock status |
| phy_done | input | 1 | PHY command complete |
| host_block | output | 1 | Block master access to memory |
| cal_en | output | 3 | Calibration enable field driven to the controller |
| refresh_en | output | 1 | Auto-refresh enable |
| refi | output | REFI_W | Refresh interval in force |
| sr_req | output | 1 | Self-refresh request |
| clk_switch | output | 1 | Clock switch request |
| phy_cmd | output | 2 | 0 none, 1 init without PHY PLL, 2 init with PHY PLL, 3 gate training |
| gate_ext | output | 1 | DQS gate-extension mode |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Sticky poll timeout flag |

## Verification
Two functions can coincide in one cycle. A new start request can arrive while a sequence is running, and the live calibration setting can change in that same cycle. Both would threaten the captured frequency and the saved calibration value. The bench provokes this by pulsing `start` with a different target and rewriting `cal_cfg` in the middle of a run. A behavioural model then judges every cycle that the run finishes with the interval and PHY command of the original target and restores the calibration value taken at acceptance. The bench also lines up the controller's exit latency so that the exit wait window and the mode poll overlap.

// File: rtl/dram_retime_seq.sv
module dram_retime_seq #(
  parameter int CLK_PER_US = 125,
  parameter int SETTLE_US  = 20,
  parameter int EXIT_US    = 200,
  parameter int POLL_MAX   = 4096,
  parameter int FREQ_W     = 12,
  parameter int REFI_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] tgt_mhz,
  input  logic [2:0]        mem_kind,
  input  logic [REFI_W-1:0] base_refi,
  input  logic [2:0]        cal_cfg,
  input  logic [2:0]        ctl_mode,
  input  logic              pll_locked,
  input  logic              phy_done,
  output logic              host_block,
  output logic [2:0]        cal_en,
  output logic              refresh_en,
  output logic [REFI_W-1:0] refi,
  output logic              sr_req,
  output logic              clk_switch,
  output logic [1:0]        phy_cmd,
  output logic              gate_ext,
  output logic              busy,
  output logic              done,
  output logic              error
);
  localparam int SET_CYC  = SETTLE_US * CLK_PER_US;
  localparam int EXIT_CYC = EXIT_US * CLK_PER_US;
  localparam int TMAX     = (SET_CYC > EXIT_CYC) ? SET_CYC : EXIT_CYC;
  localparam int TW       = $clog2(TMAX + 1);
  localparam int WW       = $clog2(POLL_MAX + 1);

  typedef enum logic [3:0] {
    IDLE, SETTLE, FREEZE, SR_IN, CLK_SW, PHY_INIT, SR_OUT,
    SR_WAIT, GATE_OFF, TRAIN, UNBLOCK, RESTORE, FAIL
  } st_t;

  st_t               st;
  logic [TW-1:0]     tmr;
  logic [WW-1:0]     wd;
  logic [2:0]        cal_q, kind_q;
  logic [FREQ_W-1:0] f_q;
  logic [REFI_W-1:0] base_q, refi_new;
  logic              poll, hit;

  wire low_pwr = (kind_q == 3'd6) || (kind_q == 3'd7);
  wire expired = (wd == WW'(POLL_MAX - 1));

  assign busy = (st != IDLE) && (st != FAIL);

  always_comb begin
    if (f_q < FREQ_W'(300))      refi_new = base_q >> 2;
    else if (f_q < FREQ_W'(672)) refi_new = base_q >> 1;
    else                         refi_new = base_q;
  end

  always_comb begin
    poll = 1'b1;
    hit  = 1'b0;
    case (st)
      SR_IN:          hit = (ctl_mode == 3'd3);
      CLK_SW:         hit = pll_locked;
      PHY_INIT, TRAIN: hit = phy_done;
      SR_WAIT:        hit = (ctl_mode == 3'd1);
      default:        poll = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; tmr <= '0; wd <= '0;
      cal_q <= '0; kind_q <= '0; f_q <= '0; base_q <= '0;
      host_block <= 1'b0; cal_en <= '0; refresh_en <= 1'b1; refi <= '0;
      sr_req <= 1'b0; clk_switch <= 1'b0; phy_cmd <= 2'd0; gate_ext <= 1'b0;
      done <= 1'b0; error <= 1'b0;
    end else begin
      done <= 1'b0;
      if (poll && !hit) begin
        if (expired) begin
          st <= FAIL;
          error <= 1'b1;
        end else begin
          wd <= wd + 1'b1;
        end
      end else begin
        case (st)
          IDLE, FAIL: begin
            if (st == IDLE) cal_en <= cal_cfg;
            if (start) begin
              st <= SETTLE; error <= 1'b0; host_block <= 1'b1;
              cal_q <= cal_cfg; kind_q <= mem_kind; f_q <= tgt_mhz; base_q <= base_refi;
              sr_req <= 1'b0; clk_switch <= 1'b0; phy_cmd <= 2'd0;
              tmr <= TW'(SET_CYC - 1);
            end
          end
          SETTLE: if (tmr == '0) st <= FREEZE; else tmr <= tmr - 1'b1;
          FREEZE: begin
            cal_en <= '0; refresh_en <= 1'b0; refi <= refi_new;
            sr_req <= 1'b1; wd <= '0; st <= SR_IN;
          end
          SR_IN: begin
            clk_switch <= 1'b1; wd <= '0; st <= CLK_SW;
          end
          CLK_SW: begin
            clk_switch <= 1'b0; wd <= '0; st <= PHY_INIT;
            phy_cmd <= (f_q <= FREQ_W'(800)) ? 2'd1 : 2'd2;
          end
          PHY_INIT: begin
            phy_cmd <= 2'd0; sr_req <= 1'b0;
            tmr <= TW'(EXIT_CYC - 1); st <= SR_OUT;
          end
          SR_OUT: if (tmr == '0) begin st <= SR_WAIT; wd <= '0; end
                  else tmr <= tmr - 1'b1;
          SR_WAIT:  begin gate_ext <= 1'b0; st <= GATE_OFF; end
          GATE_OFF: begin phy_cmd <= 2'd3; wd <= '0; st <= TRAIN; end
          TRAIN: begin
            phy_cmd <= 2'd0; gate_ext <= low_pwr; refresh_en <= 1'b1; st <= UNBLOCK;
          end
          UNBLOCK: begin host_block <= 1'b0; st <= RESTORE; end
          RESTORE: begin cal_en <= cal_q; done <= 1'b1; st <= IDLE; end
          default: st <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dram_retime_seq_chk.sv
module dram_retime_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       error,
  input logic       host_block,
  input logic       refresh_en,
  input logic [2:0] cal_en,
  input logic       sr_req,
  input logic       clk_switch,
  input logic [1:0] phy_cmd,
  input logic       gate_ext
);
  assert_busy_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || error));
  assert_cal_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_en |-> (cal_en == 3'd0));
  assert_refresh_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_en |-> host_block);
  assert_switch_in_sr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_switch |-> sr_req);
  assert_phy_after_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_cmd != 2'd0) |-> !clk_switch);
  assert_init_in_sr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_cmd == 2'd1 || phy_cmd == 2'd2) |-> sr_req);
  assert_gate_off_train_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_cmd == 2'd3) |-> !gate_ext);
  assert_err_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !busy);
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind dram_retime_seq dram_retime_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
  .host_block(host_block), .refresh_en(refresh_en), .cal_en(cal_en),
  .sr_req(sr_req), .clk_switch(clk_switch), .phy_cmd(phy_cmd), .gate_ext(gate_ext)
);

// File: tb/dram_retime_seq_test.sv
`timescale 1ns/1ps
module dram_retime_seq_test;
  localparam int CPU = 2, SET = 20 * CPU, EXT = 200 * CPU, PMAX = 50;

  logic clk = 0, rst_n = 0, start = 0;
  logic [11:0] tgt_mhz = 0, base_refi = 0;
  logic [2:0] mem_kind = 0, cal_cfg = 0, ctl_mode = 3'd1;
  logic pll_locked = 0, phy_done = 0;
  logic host_block, refresh_en, sr_req, clk_switch, gate_ext, busy, done, error;
  logic [2:0] cal_en; logic [11:0] refi; logic [1:0] phy_cmd;

  int checks = 0, fails = 0, cyc = 0;
  int pll_lat = 5, phy_lat = 7, srin_lat = 4, srout_lat = 10;
  bit pll_hang = 0;
  int pcnt = 0, dcnt = 0, mcnt = 0;
  int seen_init = 0;

  always #4 clk = ~clk;

  dram_retime_seq #(.CLK_PER_US(CPU), .SETTLE_US(20), .EXIT_US(200), .POLL_MAX(PMAX),
                    .FREQ_W(12), .REFI_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_mhz(tgt_mhz), .mem_kind(mem_kind),
    .base_refi(base_refi), .cal_cfg(cal_cfg), .ctl_mode(ctl_mode), .pll_locked(pll_locked),
    .phy_done(phy_done), .host_block(host_block), .cal_en(cal_en), .refresh_en(refresh_en),
    .refi(refi), .sr_req(sr_req), .clk_switch(clk_switch), .phy_cmd(phy_cmd),
    .gate_ext(gate_ext), .busy(busy), .done(done), .error(error));

  // external responders
  always @(posedge clk) begin
    if (clk_switch && !pll_hang) begin
      if (pcnt >= pll_lat) pll_locked <= 1; else pcnt <= pcnt + 1;
    end else begin pcnt <= 0; pll_locked <= 0; end
    if (phy_cmd != 0) begin
      if (dcnt >= phy_lat) phy_done <= 1; else dcnt <= dcnt + 1;
    end else begin dcnt <= 0; phy_done <= 0; end
    if (sr_req && ctl_mode != 3) begin
      if (mcnt >= srin_lat) begin ctl_mode <= 3; mcnt <= 0; end else mcnt <= mcnt + 1;
    end else if (!sr_req && ctl_mode != 1) begin
      if (mcnt >= srout_lat) begin ctl_mode <= 1; mcnt <= 0; end else mcnt <= mcnt + 1;
    end else mcnt <= 0;
  end

  function automatic int exp_refi(int f, int b);
    if (f < 300) return b / 4;
    if (f < 672) return b / 2;
    return b;
  endfunction

  // behavioural reference model, stepped on each rising edge
  int ph = 0, tm = 0, wd = 0, cal_s = 0, f_s = 0, k_s = 0, b_s = 0;
  int m_cal = 0, m_refi = 0, m_cmd = 0;
  bit m_hb = 0, m_ref = 1, m_sr = 0, m_cs = 0, m_gx = 0, m_done = 0, m_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_cal = 0; m_refi = 0; m_cmd = 0; m_hb = 0; m_ref = 1; m_sr = 0;
      m_cs = 0; m_gx = 0; m_done = 0; m_err = 0;
    end else begin
      bit waiting, ok;
      m_done = 0;
      waiting = (ph == 3 || ph == 4 || ph == 5 || ph == 7 || ph == 9);
      ok = (ph == 3 && ctl_mode == 3) || (ph == 4 && pll_locked) ||
           ((ph == 5 || ph == 9) && phy_done) || (ph == 7 && ctl_mode == 1);
      if (waiting && !ok) begin
        if (wd == PMAX - 1) begin ph = 12; m_err = 1; end else wd++;
      end else begin
        case (ph)
          0, 12: begin
            if (ph == 0) m_cal = cal_cfg;
            if (start) begin
              ph = 1; m_err = 0; m_hb = 1; cal_s = cal_cfg; f_s = tgt_mhz; k_s = mem_kind;
              b_s = base_refi; m_sr = 0; m_cs = 0; m_cmd = 0; tm = SET;
            end
          end
          1: begin tm--; if (tm == 0) ph = 2; end
          2: begin m_cal = 0; m_ref = 0; m_refi = exp_refi(f_s, b_s); m_sr = 1; wd = 0; ph = 3; end
          3: begin m_cs = 1; wd = 0; ph = 4; end
          4: begin m_cs = 0; wd = 0; m_cmd = (f_s <= 800) ? 1 : 2; ph = 5; end
          5: begin m_cmd = 0; m_sr = 0; tm = EXT; ph = 6; end
          6: begin tm--; if (tm == 0) begin ph = 7; wd = 0; end end
          7: begin m_gx = 0; ph = 8; end
          8: begin m_cmd = 3; wd = 0; ph = 9; end
          9: begin m_cmd = 0; m_gx = (k_s == 6 || k_s == 7); m_ref = 1; ph = 10; end
          10: begin m_hb = 0; ph = 11; end
          11: begin m_cal = cal_s; m_done = 1; ph = 0; end
          default: ph = 0;
        endcase
      end
    end
  end

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    cmp("R1 busy", busy, (ph != 0 && ph != 12));
    cmp("R2 host_block", host_block, m_hb);
    cmp("R3 cal_en", cal_en, m_cal);
    cmp("R4 refresh_en", refresh_en, m_ref);
    cmp("R5 refi", refi, m_refi);
    cmp("R6 sr_req", sr_req, m_sr);
    cmp("R7 clk_switch", clk_switch, m_cs);
    cmp("R8 phy_cmd", phy_cmd, m_cmd);
    cmp("R9 gate_ext", gate_ext, m_gx);
    cmp("R10 error", error, m_err);
    cmp("R11 done", done, m_done);
    if (phy_cmd == 1 || phy_cmd == 2) seen_init = phy_cmd;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, fails);
      $finish;
    end
  end

  task automatic run(int f, int k, int b, int cal, bit poke);
    @(negedge clk);
    tgt_mhz = f[11:0]; mem_kind = k[2:0]; base_refi = b[11:0]; cal_cfg = cal[2:0];
    start = 1; seen_init = 0;
    @(negedge clk); start = 0;
    cmp("R1 busy after accept", busy, 1);
    cmp("R2 host_block after accept", host_block, 1);
    if (poke) begin
      repeat (60) @(negedge clk);
      start = 1; tgt_mhz = 12'd900; cal_cfg = ~cal[2:0];
      @(negedge clk); start = 0;
      cmp("R1 busy ignores start", busy, 1);
    end
    for (int i = 0; i < 5000 && !(done || error); i++) @(negedge clk);
  endtask

  task automatic finish_checks(int f, int k, int b, int cal);
    cmp("R11 done pulse", done, 1);
    cmp("R11 busy low at done", busy, 0);
    cmp("R5 final refi", refi, exp_refi(f, b));
    cmp("R3 restored cal", cal_en, cal);
    cmp("R9 final gate_ext", gate_ext, (k == 6 || k == 7));
    cmp("R8 init command", seen_init, (f <= 800) ? 1 : 2);
    cmp("R4 refresh on", refresh_en, 1);
    @(negedge clk);
    cmp("R11 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 reset busy", busy, 0);
    cmp("R4 reset refresh_en", refresh_en, 1);
    cmp("R10 reset error", error, 0);
    rst_n = 1;
    @(negedge clk); cal_cfg = 3'b011;
    @(negedge clk); @(negedge clk);
    cmp("R3 idle tracking", cal_en, 3);

    run(200, 3, 12'hABC, 5, 0);  finish_checks(200, 3, 12'hABC, 5);
    run(300, 6, 12'h7F3, 6, 1);  finish_checks(300, 6, 12'h7F3, 6);
    run(671, 2, 12'h801, 1, 0);  finish_checks(671, 2, 12'h801, 1);
    srout_lat = 420;
    run(672, 7, 12'h555, 7, 0);  finish_checks(672, 7, 12'h555, 7);
    srout_lat = 10;
    run(801, 3, 12'hFFF, 2, 0);  finish_checks(801, 3, 12'hFFF, 2);
    run(800, 6, 12'h123, 4, 0);  finish_checks(800, 6, 12'h123, 4);
    run(299, 3, 12'h3FF, 3, 0);  finish_checks(299, 3, 12'h3FF, 3);

    pll_hang = 1;
    run(500, 3, 12'h400, 5, 0);
    cmp("R10 error on timeout", error, 1);
    cmp("R10 busy low in error", busy, 0);
    repeat (5) @(negedge clk);
    cmp("R10 held in error", error, 1);
    cmp("R10 clk_switch held", clk_switch, 1);
    pll_hang = 0;
    run(500, 3, 12'h400, 5, 0);  finish_checks(500, 3, 12'h400, 5);
    cmp("R10 error cleared", error, 0);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, fails);
    $finish;
  end
endmodule